// File: doc/BRIEF.md
# DRAM Low-Power Entry and Exit Sequencer

This controller-side block decides when a DDR2-style memory device goes into its power-saving state and when it comes back out. When the scheduler has nothing to send, it raises a power-down request. The sequencer then lowers the clock-enable pin and takes the command bus away from the scheduler. While the pin is low, the bus carries only NOP codes.

The sequencer also picks the kind of sleep. If every bank is closed at the moment of entry, it uses the precharged flavour. If any bank still has an open row, it uses an active flavour. Each flavour has its own wake-up latency. For active sleep, a static configuration bit chooses fast exit (the device DLL stays running) or slow exit (the DLL is stopped).

Three things end a sleep: a wake request, a refresh-urgency signal, or a sleep-length budget of nine refresh intervals running out. In every case the sequencer first respects the minimum clock-enable pulse width. It then raises the pin with a NOP on the bus. Commands stay blocked until the exit latency has passed. The scheduler's commands flow through `cmd_in` and are forwarded only while `cmd_ready` is high. Any code presented while `cmd_ready` is low is replaced by NOP and is not consumed, so the scheduler must hold it. All timing values are cycle counts taken from configuration inputs, and these inputs are expected to stay stable while the block is in use.

Top module: `dram_pd_seq`

## Requirements
- R1: After reset, `cke` is 1, `cmd_ready` is 1 and `cmd_out` equals `cmd_in`.
- R2: In the running state, if `pd_req` is high, `wake_req` and `refresh_urgent` are low and the high-pulse window of R8 is over, then one clock edge later `cke` is 0, `cmd_ready` is 0 and `cmd_out` is the NOP code (all ones).
- R3: Once `cke` has fallen, it stays low for at least max(`cfg_t_cke`,1) cycles. A `wake_req` pulse that arrives inside this window is held, and `cke` rises exactly when the window ends. A `wake_req` that arrives after the window raises `cke` at the next edge.
- R4: `cmd_ready` is high only while `cke` is high. Whenever `cmd_ready` is low, `cmd_out` is all ones (NOP). Whenever `cmd_ready` is high, `cmd_out` equals `cmd_in`.
- R5: If all bits of `bank_open` are 0 at entry (precharged sleep), `cmd_ready` rises max(`cfg_t_xp`,1) cycles after `cke` rises.
- R6: If any bit of `bank_open` is 1 at entry and `cfg_slow_exit` is 0 (fast active sleep), `cmd_ready` rises max(`cfg_t_xard`,1) cycles after `cke` rises.
- R7: If any bit of `bank_open` is 1 at entry and `cfg_slow_exit` is 1 (slow active sleep), `cmd_ready` rises max(`cfg_t_xards`,1) cycles after `cke` rises.
- R8: After `cke` rises, it stays high for at least max(`cfg_t_cke`,1) cycles before it may fall again, even if `pd_req` stays high throughout.
- R9: If nothing else wakes the device, `cke` rises max(9×`cfg_t_refi`, max(`cfg_t_cke`,1)) cycles after it fell.
- R10: While asleep, a high `refresh_urgent` forces an exit under the same pulse-width rule as a wake. While running, a high `refresh_urgent` or `wake_req` refuses entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Scheduler is idle and asks for low-power mode |
| bank_open | input | NBANK | One bit per bank, 1 = a row is open |
| wake_req | input | 1 | Request to leave low-power mode |
| refresh_urgent | input | 1 | Refresh is due; forces exit and blocks entry |
| cfg_t_cke | input | CW | Minimum clock-enable pulse width, cycles |
| cfg_t_xp | input | CW | Exit latency after precharged sleep |
| cfg_t_xard | input | CW | Exit latency after fast active sleep |
| cfg_t_xards | input | CW | Exit latency after slow active sleep |
| cfg_t_refi | input | CW | Refresh interval, cycles |
| cfg_slow_exit | input | 1 | 1 = active sleep uses slow exit |
| cmd_in | input | CMDW | Command code from the scheduler |
| cke | output | 1 | Clock enable to the device |
| cmd_out | output | CMDW | Command code to the device |
| cmd_ready | output | 1 | Scheduler commands are being forwarded |

## Verification
Every wrong internal state in this block shows up as a clock-enable or ready edge that lands on the wrong cycle.

- If the sleep flavour is latched wrongly, `cmd_ready` returns one of the other latency counts after `cke` rises, and the error appears within a few cycles of the exit.
- If a wake pulse that came inside the minimum-low window is lost, `cke` stays low until the refresh budget runs out.
- If the shared pulse-width counter is mishandled, the second entry of a back-to-back sleep comes too early.

The bench predicts each of these edges to the exact cycle and also checks the command mux on every cycle.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [1:0] {
    PD_PRECHG   = 2'd0,
    PD_ACT_FAST = 2'd1,
    PD_ACT_SLOW = 2'd2
  } pd_kind_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/dpd_timer.sv
module dpd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  // window of N cycles closes on the edge where the count reaches one
  assign expired = (cnt <= W'(1));
endmodule

// File: rtl/dpd_mode_sel.sv
module dpd_mode_sel
  import dpd_pkg::*;
#(
  parameter int NB = 4,
  parameter int W  = 8
) (
  input  logic [NB-1:0] bank_open,
  input  logic          slow_exit,
  input  pd_kind_e      kind_q,
  input  logic [W-1:0]  t_xp,
  input  logic [W-1:0]  t_xard,
  input  logic [W-1:0]  t_xards,
  output pd_kind_e      kind_now,
  output logic [W-1:0]  exit_lat
);
  always_comb begin
    if (|bank_open) kind_now = slow_exit ? PD_ACT_SLOW : PD_ACT_FAST;
    else            kind_now = PD_PRECHG;
  end

  always_comb begin
    case (kind_q)
      PD_ACT_FAST: exit_lat = t_xard;
      PD_ACT_SLOW: exit_lat = t_xards;
      default:     exit_lat = t_xp;
    endcase
  end
endmodule

// File: rtl/dram_pd_seq.sv
module dram_pd_seq
  import dpd_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int CW    = 8,
  parameter int CMDW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic [NBANK-1:0] bank_open,
  input  logic             wake_req,
  input  logic             refresh_urgent,
  input  logic [CW-1:0]    cfg_t_cke,
  input  logic [CW-1:0]    cfg_t_xp,
  input  logic [CW-1:0]    cfg_t_xard,
  input  logic [CW-1:0]    cfg_t_xards,
  input  logic [CW-1:0]    cfg_t_refi,
  input  logic             cfg_slow_exit,
  input  logic [CMDW-1:0]  cmd_in,
  output logic             cke,
  output logic [CMDW-1:0]  cmd_out,
  output logic             cmd_ready
);
  localparam int BW = CW + 4;          // holds 9 x refresh interval
  localparam int LW = CW + 5;          // checker run-length counters
  localparam logic [CMDW-1:0] NOP = '1;

  seq_st_e  st;
  pd_kind_e kind_q, kind_now;
  logic     wake_pend;
  logic     cke_exp, exit_exp, bud_exp;
  logic     enter, leave;
  logic [CW-1:0] exit_lat;
  logic [BW-1:0] budget;

  assign budget = ({4'b0, cfg_t_refi} << 3) + {4'b0, cfg_t_refi};

  dpd_mode_sel #(.NB(NBANK), .W(CW)) u_mode (
    .bank_open (bank_open),
    .slow_exit (cfg_slow_exit),
    .kind_q    (kind_q),
    .t_xp      (cfg_t_xp),
    .t_xard    (cfg_t_xard),
    .t_xards   (cfg_t_xards),
    .kind_now  (kind_now),
    .exit_lat  (exit_lat)
  );

  // one timer covers both the low and the high pulse window
  dpd_timer #(.W(CW)) u_cke_tmr (
    .clk(clk), .rst_n(rst_n), .load(enter | leave),
    .load_val(cfg_t_cke), .expired(cke_exp)
  );

  dpd_timer #(.W(CW)) u_exit_tmr (
    .clk(clk), .rst_n(rst_n), .load(leave),
    .load_val(exit_lat), .expired(exit_exp)
  );

  dpd_timer #(.W(BW)) u_bud_tmr (
    .clk(clk), .rst_n(rst_n), .load(enter),
    .load_val(budget), .expired(bud_exp)
  );

  assign enter = (st == ST_RUN) && pd_req && !wake_req && !refresh_urgent && cke_exp;
  assign leave = (st == ST_SLEEP) && cke_exp &&
                 (wake_req || wake_pend || refresh_urgent || bud_exp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_RUN;
      kind_q    <= PD_PRECHG;
      wake_pend <= 1'b0;
      cke       <= 1'b1;
    end else begin
      case (st)
        ST_RUN: begin
          wake_pend <= 1'b0;
          if (enter) begin
            st     <= ST_SLEEP;
            cke    <= 1'b0;
            kind_q <= kind_now;
          end
        end
        ST_SLEEP: begin
          if (leave) begin
            st        <= ST_WAKE;
            cke       <= 1'b1;
            wake_pend <= 1'b0;
          end else begin
            wake_pend <= wake_pend | wake_req;
          end
        end
        ST_WAKE: begin
          if (exit_exp) st <= ST_RUN;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign cmd_ready = (st == ST_RUN);
  assign cmd_out   = cmd_ready ? cmd_in : NOP;

  // ---------------- checker counters and assertions ----------------
  logic [LW-1:0] lo_len, hi_len;
  logic [LW-1:0] min_cke, lat_min, sleep_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= '1;
    end else begin
      lo_len <= cke ? '0 : ((lo_len != '1) ? lo_len + LW'(1) : lo_len);
      hi_len <= !cke ? '0 : ((hi_len != '1) ? hi_len + LW'(1) : hi_len);
    end
  end

  assign min_cke   = (cfg_t_cke == '0) ? LW'(1) : LW'(cfg_t_cke);
  assign lat_min   = (exit_lat == '0) ? LW'(1) : LW'(exit_lat);
  assign sleep_cap = (LW'(budget) > min_cke) ? LW'(budget) : min_cke;

  AST_READY_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> cke);                                               // R4
  AST_NOP_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd_out == NOP) && !cmd_ready);                   // R2
  AST_MIN_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> lo_len >= min_cke);                                // R3
  AST_MIN_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> hi_len >= min_cke);                                // R8
  AST_SLEEP_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> lo_len < sleep_cap);                                     // R9
  AST_EXIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> hi_len >= lat_min);                          // R5
endmodule

// File: tb/dram_pd_seq_tb_top.sv
module dram_pd_seq_tb_top;
  localparam int NB = 4;
  localparam int CW = 8;
  localparam int CMDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, wake_req = 1'b0, refresh_urgent = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [CW-1:0] t_cke = 8'd3, t_xp = 8'd1, t_xard = 8'd4, t_xards = 8'd7, t_refi = 8'd4;
  logic slow_exit = 1'b0;
  logic [CMDW-1:0] cmd_in = '0;
  logic cke, cmd_ready;
  logic [CMDW-1:0] cmd_out;

  always #10 clk = ~clk;   // 50 MHz

  dram_pd_seq #(.NBANK(NB), .CW(CW), .CMDW(CMDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .bank_open(bank_open),
    .wake_req(wake_req), .refresh_urgent(refresh_urgent),
    .cfg_t_cke(t_cke), .cfg_t_xp(t_xp), .cfg_t_xard(t_xard),
    .cfg_t_xards(t_xards), .cfg_t_refi(t_refi), .cfg_slow_exit(slow_exit),
    .cmd_in(cmd_in), .cke(cke), .cmd_out(cmd_out), .cmd_ready(cmd_ready)
  );

  typedef struct { string kind; int cyc; string req; } ev_t;
  ev_t exp_q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit mon_en = 0, done = 0;
  logic p_cke = 1'b1, p_rdy = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) cmd_in <= cmd_in + 3'd3;

  task automatic push(input string k, input int c, input string r);
    ev_t e;
    e.kind = k; e.cyc = c; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic check_event(input string k);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected: got %s@%0d expected no event", k, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.cyc != cyc) begin
        n_fail++;
        $display("FAIL %s: got %s@%0d expected %s@%0d", e.req, k, cyc, e.kind, e.cyc);
      end
    end
  endtask

  task automatic expect_high(input string r);
    n_chk++;
    if (cke !== 1'b1 || cmd_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: got cke=%b ready=%b expected cke=1 ready=1", r, cke, cmd_ready);
    end
  endtask

  // monitor: pops expected edges and checks the command mux every cycle
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      if (cke !== p_cke) check_event(cke ? "cke_rise" : "cke_fall");
      if (cmd_ready !== p_rdy) check_event(cmd_ready ? "rdy_rise" : "rdy_fall");
      n_chk++;
      if (cmd_ready && cmd_out !== cmd_in) begin
        n_fail++;
        $display("FAIL R4: got cmd_out=%b expected %b", cmd_out, cmd_in);
      end else if (!cmd_ready && cmd_out !== 3'b111) begin
        n_fail++;
        $display("FAIL R4: got cmd_out=%b expected 111", cmd_out);
      end
      p_cke = cke;
      p_rdy = cmd_ready;
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    n_chk++;
    if (cke !== 1'b1 || cmd_ready !== 1'b1 || cmd_out !== cmd_in) begin
      n_fail++;
      $display("FAIL R1: got cke=%b rdy=%b out=%b expected 1 1 %b", cke, cmd_ready, cmd_out, cmd_in);
    end
    mon_en = 1;
    repeat (4) @(negedge clk);

    // A: precharged sleep, wake inside the minimum-low window (R2 R3 R5)
    @(negedge clk); bank_open = '0; pd_req = 1; c0 = cyc;
    push("cke_fall", c0+1, "R2"); push("rdy_fall", c0+1, "R2");
    push("cke_rise", c0+4, "R3"); push("rdy_rise", c0+5, "R5");
    @(negedge clk); pd_req = 0; wake_req = 1;
    @(negedge clk); wake_req = 0;
    repeat (10) @(negedge clk);

    // B: fast active sleep, wake after the window (R6 R3)
    @(negedge clk); bank_open = 4'b0100; slow_exit = 0; pd_req = 1; c0 = cyc;
    push("cke_fall", c0+1, "R2"); push("rdy_fall", c0+1, "R2");
    push("cke_rise", c0+7, "R3"); push("rdy_rise", c0+11, "R6");
    @(negedge clk); pd_req = 0;
    repeat (5) @(negedge clk); wake_req = 1;
    @(negedge clk); wake_req = 0;
    repeat (12) @(negedge clk);

    // C: slow active sleep (R7)
    @(negedge clk); bank_open = 4'b1000; slow_exit = 1; pd_req = 1; c0 = cyc;
    push("cke_fall", c0+1, "R2"); push("rdy_fall", c0+1, "R2");
    push("cke_rise", c0+4, "R3"); push("rdy_rise", c0+11, "R7");
    @(negedge clk); pd_req = 0;
    @(negedge clk); wake_req = 1;
    @(negedge clk); wake_req = 0;
    repeat (12) @(negedge clk);
    slow_exit = 0;

    // D: no wake, budget of 9 x 4 cycles ends sleep (R9)
    @(negedge clk); bank_open = '0; pd_req = 1; c0 = cyc;
    push("cke_fall", c0+1, "R2"); push("rdy_fall", c0+1, "R2");
    push("cke_rise", c0+37, "R9"); push("rdy_rise", c0+38, "R9");
    @(negedge clk); pd_req = 0;
    repeat (45) @(negedge clk);

    // E: refresh urgency forces exit, then blocks entry (R10)
    @(negedge clk); pd_req = 1; c0 = cyc;
    push("cke_fall", c0+1, "R2"); push("rdy_fall", c0+1, "R2");
    push("cke_rise", c0+6, "R10"); push("rdy_rise", c0+7, "R10");
    @(negedge clk); pd_req = 0;
    repeat (4) @(negedge clk); refresh_urgent = 1;
    repeat (3) @(negedge clk); pd_req = 1;
    repeat (4) @(negedge clk); #2; expect_high("R10");
    pd_req = 0; refresh_urgent = 0;
    repeat (5) @(negedge clk);

    // G: wake request in the running state refuses entry (R10)
    @(negedge clk); pd_req = 1; wake_req = 1;
    repeat (4) @(negedge clk); #2; expect_high("R10");
    pd_req = 0; wake_req = 0;
    repeat (5) @(negedge clk);

    // F: request held through exit, high window delays re-entry (R8)
    @(negedge clk); bank_open = '0; pd_req = 1; c0 = cyc;
    push("cke_fall", c0+1, "R2"); push("rdy_fall", c0+1, "R2");
    push("cke_rise", c0+4, "R3"); push("rdy_rise", c0+5, "R5");
    push("cke_fall", c0+7, "R8"); push("rdy_fall", c0+7, "R8");
    push("cke_rise", c0+13, "R3"); push("rdy_rise", c0+14, "R5");
    @(negedge clk); wake_req = 1;
    @(negedge clk); wake_req = 0;
    repeat (5) @(negedge clk); pd_req = 0;
    repeat (5) @(negedge clk); wake_req = 1;
    @(negedge clk); wake_req = 0;
    repeat (8) @(negedge clk);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3: got %0d pending events expected 0", exp_q.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule